// File: doc/BRIEF.md
# Instruction header decoder

The block sits behind an instruction fetch stream and turns the first one or two 16-bit words of each instruction into a decoded header. The first word always arrives. It carries a lock prefix, a flag that says whether a second header word follows, and the opcode index. The optional second word carries a repeat prefix, a condition code and one format field for each of the two operands.

Each opcode has a signature: two parameter kinds, each one of none, register, immediate or memory. The signatures come from a table passed in as a parameter. The decoder checks the opcode index against the number of defined opcodes and checks both format fields against the signature. It then issues one of two results. The first is a one-cycle header strobe with all fields valid. The second is an illegal-instruction fault, which is held until the consumer acknowledges it.

Operand payload words, condition evaluation and execution belong to the stages downstream. The decoder takes no word while it is presenting a result.

Top module: `hdr_decoder`

## Requirements
- R1: After reset, `hdr_valid_o` and `fault_o` are 0 and `word_ready_o` is 1.
- R2: In the first word, bit 15 is the lock prefix, bit 14 set means a second word follows, and bits 13:0 are the opcode. On a strobe, `lock_o` and `opcode_o` carry these values.
- R3: In the second word, bit 15 is the repeat prefix, bits 14:10 are the condition, bits 9:5 are operand format 1 and bits 4:0 are operand format 2. On a strobe, `rep_o`, `cond_o`, `fmt1_o` and `fmt2_o` carry these values.
- R4: When bit 14 of the first word is 0, only one word is consumed, and repeat, condition and both formats are taken as 0.
- R5: An opcode of NUM_OPS or above raises a fault right after the first word. Any second word is not consumed, and no strobe is issued.
- R6: A parameter slot of kind none (code 0) requires format 0. Any other format faults, which covers zero-parameter and one-parameter opcodes.
- R7: A slot of kind register (code 1) requires format 1. A slot of kind immediate (code 2) requires format 2.
- R8: A slot of kind memory (code 4) requires a format from 4 to 19 inclusive. Formats 0 to 3 and 20 to 31 fault.
- R9: Each instruction yields exactly one result: either a strobe or a fault. It appears in the cycle after the edge that accepts the last word. A strobe lasts one cycle, and `word_ready_o` is 0 while it is shown.
- R10: A fault stays high with `word_ready_o` at 0 until `fault_ack_i` is sampled high, and words offered meanwhile are ignored. In the cycle after the acknowledging edge, `fault_o` is 0 and `word_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Fetch word valid |
| word_i | input | 16 | Fetch word |
| word_ready_o | output | 1 | Decoder accepts a word this cycle |
| hdr_valid_o | output | 1 | One-cycle strobe for a legal header |
| opcode_o | output | 14 | Opcode index |
| lock_o | output | 1 | Lock prefix |
| rep_o | output | 1 | Repeat prefix |
| cond_o | output | 5 | Condition code |
| fmt1_o | output | 5 | Operand 1 format |
| fmt2_o | output | 5 | Operand 2 format |
| fault_o | output | 1 | Illegal-instruction fault, held until acknowledged |
| fault_ack_i | input | 1 | Fault acknowledge |

## Verification
The strobe or the fault becomes visible in the cycle after the rising edge that accepts the last header word. For R5 that edge is the one accepting the first word. The strobe is gone one cycle later, and a fault clears in the cycle after the acknowledging edge. The bench drives every word and acknowledge on a falling edge and samples at the next falling edge, so each result is read in the one cycle where it is due. An extra sample one cycle later confirms that the strobe has ended and that ready has returned. A sweep over every defined opcode, two undefined ones and all 1024 format pairs covers every slot rule.

// File: rtl/hdr_dec_pkg.sv
package hdr_dec_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 14;
  localparam int KIND_W = 3;
  localparam int ENT_W  = 2 * KIND_W;
  localparam int FMT_W  = 5;
  localparam int COND_W = 5;

  localparam logic [FMT_W-1:0] FMT_NONE   = 5'd0;
  localparam logic [FMT_W-1:0] FMT_REG    = 5'd1;
  localparam logic [FMT_W-1:0] FMT_IMM    = 5'd2;
  localparam logic [FMT_W-1:0] FMT_MEM_LO = 5'd4;
  localparam logic [FMT_W-1:0] FMT_MEM_HI = 5'd19;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE = 3'd0,
    KIND_REG  = 3'd1,
    KIND_IMM  = 3'd2,
    KIND_MEM  = 3'd4
  } kind_e;

  typedef struct packed {
    logic            lock;
    logic            more;
    logic [OP_W-1:0] opcode;
  } head_word_t;

  typedef struct packed {
    logic              rep;
    logic [COND_W-1:0] cond;
    logic [FMT_W-1:0]  fmt1;
    logic [FMT_W-1:0]  fmt2;
  } tail_word_t;

  typedef enum logic [1:0] {
    ST_HEAD, ST_TAIL, ST_DONE, ST_FAULT
  } state_e;
endpackage

// File: rtl/hdr_sig_lookup.sv
module hdr_sig_lookup
  import hdr_dec_pkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter logic [NUM_OPS*ENT_W-1:0] SIG_TABLE = '0
) (
  input  logic [OP_W-1:0]   opcode_i,
  output logic              known_o,
  output logic [KIND_W-1:0] kind1_o,
  output logic [KIND_W-1:0] kind2_o
);
  assign known_o = opcode_i < OP_W'(NUM_OPS);

  // entry i: {kind1, kind2} at bits [i*ENT_W +: ENT_W]
  always_comb begin
    kind1_o = '0;
    kind2_o = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (opcode_i == OP_W'(i)) begin
        kind1_o = SIG_TABLE[i*ENT_W+KIND_W +: KIND_W];
        kind2_o = SIG_TABLE[i*ENT_W +: KIND_W];
      end
    end
  end
endmodule

// File: rtl/hdr_fmt_check.sv
module hdr_fmt_check
  import hdr_dec_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic [FMT_W-1:0]  fmt_i,
  output logic              ok_o
);
  always_comb begin
    unique case (kind_i)
      KIND_NONE: ok_o = (fmt_i == FMT_NONE);
      KIND_REG:  ok_o = (fmt_i == FMT_REG);
      KIND_IMM:  ok_o = (fmt_i == FMT_IMM);
      KIND_MEM:  ok_o = (fmt_i >= FMT_MEM_LO) && (fmt_i <= FMT_MEM_HI);
      default:   ok_o = 1'b0;  // undefined kind codes never match
    endcase
  end
endmodule

// File: rtl/hdr_decoder.sv
module hdr_decoder
  import hdr_dec_pkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter logic [NUM_OPS*ENT_W-1:0] SIG_TABLE =
    {6'o22, 6'o14, 6'o41, 6'o12, 6'o11, 6'o40, 6'o10, 6'o00}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              hdr_valid_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic              lock_o,
  output logic              rep_o,
  output logic [COND_W-1:0] cond_o,
  output logic [FMT_W-1:0]  fmt1_o,
  output logic [FMT_W-1:0]  fmt2_o,
  output logic              fault_o,
  input  logic              fault_ack_i
);
  state_e     state_q, state_d;
  head_word_t head_w;
  tail_word_t tail_w;
  logic       accept;
  logic [OP_W-1:0]  chk_op;
  logic [FMT_W-1:0] chk_fmt [2];
  logic [KIND_W-1:0] kind [2];
  logic       ok [2];
  logic       known;

  assign head_w = head_word_t'(word_i);
  assign tail_w = tail_word_t'(word_i);

  assign word_ready_o = (state_q == ST_HEAD) || (state_q == ST_TAIL);
  assign hdr_valid_o  = (state_q == ST_DONE);
  assign fault_o      = (state_q == ST_FAULT);
  assign accept       = word_valid_i && word_ready_o;

  // single-word headers are checked with both formats at zero
  always_comb begin
    if (state_q == ST_TAIL) begin
      chk_op     = opcode_o;
      chk_fmt[0] = tail_w.fmt1;
      chk_fmt[1] = tail_w.fmt2;
    end else begin
      chk_op     = head_w.opcode;
      chk_fmt[0] = FMT_NONE;
      chk_fmt[1] = FMT_NONE;
    end
  end

  hdr_sig_lookup #(.NUM_OPS(NUM_OPS), .SIG_TABLE(SIG_TABLE)) i_lookup (
    .opcode_i (chk_op),
    .known_o  (known),
    .kind1_o  (kind[0]),
    .kind2_o  (kind[1])
  );

  for (genvar s = 0; s < 2; s++) begin : g_slot
    hdr_fmt_check i_check (
      .kind_i (kind[s]),
      .fmt_i  (chk_fmt[s]),
      .ok_o   (ok[s])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HEAD: if (accept) begin
        if (!known)            state_d = ST_FAULT;
        else if (head_w.more)  state_d = ST_TAIL;
        else if (ok[0] && ok[1]) state_d = ST_DONE;
        else                   state_d = ST_FAULT;
      end
      ST_TAIL: if (accept) state_d = (ok[0] && ok[1]) ? ST_DONE : ST_FAULT;
      ST_DONE:  state_d = ST_HEAD;
      ST_FAULT: if (fault_ack_i) state_d = ST_HEAD;
      default:  state_d = ST_HEAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HEAD;
      opcode_o <= '0;
      lock_o   <= 1'b0;
      rep_o    <= 1'b0;
      cond_o   <= '0;
      fmt1_o   <= '0;
      fmt2_o   <= '0;
    end else begin
      state_q <= state_d;
      if (accept && state_q == ST_HEAD) begin
        opcode_o <= head_w.opcode;
        lock_o   <= head_w.lock;
        rep_o    <= 1'b0;
        cond_o   <= '0;
        fmt1_o   <= '0;
        fmt2_o   <= '0;
      end else if (accept && state_q == ST_TAIL) begin
        rep_o  <= tail_w.rep;
        cond_o <= tail_w.cond;
        fmt1_o <= tail_w.fmt1;
        fmt2_o <= tail_w.fmt2;
      end
    end
  end
endmodule

// File: rtl/hdr_decoder_chk.sv
module hdr_decoder_chk
  import hdr_dec_pkg::*;
#(
  parameter int NUM_OPS = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            word_ready_o,
  input logic            hdr_valid_o,
  input logic            fault_o,
  input logic            fault_ack_i,
  input logic [OP_W-1:0] opcode_o,
  input logic [FMT_W-1:0] fmt1_o,
  input logic [FMT_W-1:0] fmt2_o
);
  assert_one_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_valid_o && fault_o));

  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o);

  assert_busy_on_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> !word_ready_o);

  assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_ack_i) |=> (fault_o && !word_ready_o));

  assert_fault_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && fault_ack_i) |=> (!fault_o && word_ready_o));

  assert_known_op_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (opcode_o < OP_W'(NUM_OPS)));

  assert_fmt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (fmt1_o <= FMT_MEM_HI && fmt2_o <= FMT_MEM_HI));
endmodule

bind hdr_decoder hdr_decoder_chk #(.NUM_OPS(NUM_OPS)) i_hdr_decoder_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_ready_o (word_ready_o),
  .hdr_valid_o  (hdr_valid_o),
  .fault_o      (fault_o),
  .fault_ack_i  (fault_ack_i),
  .opcode_o     (opcode_o),
  .fmt1_o       (fmt1_o),
  .fmt2_o       (fmt2_o)
);

// File: tb/test_hdr_decoder.sv
module test_hdr_decoder;
  localparam int NOPS = 8;
  // kinds: 0 none, 1 reg, 2 imm, 4 mem ; entry {k1,k2}
  localparam logic [NOPS*6-1:0] TABLE =
    {6'o22, 6'o14, 6'o41, 6'o12, 6'o11, 6'o40, 6'o10, 6'o00};
  int k1 [NOPS] = '{0, 1, 4, 1, 1, 4, 1, 2};
  int k2 [NOPS] = '{0, 0, 0, 1, 2, 1, 4, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wvalid = 1'b0, ack = 1'b0;
  logic [15:0] wdata = '0;
  logic ready, hvalid, lock, rep, fault;
  logic [13:0] opc;
  logic [4:0] cond, f1, f2;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdr_decoder #(.NUM_OPS(NOPS), .SIG_TABLE(TABLE)) i_hdr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(wvalid), .word_i(wdata),
    .word_ready_o(ready), .hdr_valid_o(hvalid), .opcode_o(opc), .lock_o(lock),
    .rep_o(rep), .cond_o(cond), .fmt1_o(f1), .fmt2_o(f2), .fault_o(fault),
    .fault_ack_i(ack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fmt_ok(input int kind, input int f);
    case (kind)
      0: return f == 0;
      1: return f == 1;
      2: return f == 2;
      4: return f >= 4 && f <= 19;
      default: return 0;
    endcase
  endfunction

  // issue one instruction, check the result in the cycle it is due
  task automatic run_instr(input int op, input bit lk, input bit two,
                           input bit rp, input int cd, input int a, input int b);
    bit exp_fault;
    exp_fault = (op >= NOPS);
    if (!exp_fault) exp_fault = !(fmt_ok(k1[op], two ? a : 0) && fmt_ok(k2[op], two ? b : 0));
    @(negedge clk);
    wvalid = 1'b1;
    wdata = {lk, two, 14'(op)};
    @(negedge clk);
    if (two && op < NOPS) begin
      chk(ready && !hvalid && !fault, "R2 waits for second word", int'({ready, hvalid, fault}), 4);
      wdata = {rp, 5'(cd), 5'(a), 5'(b)};
      @(negedge clk);
    end
    wvalid = 1'b0;
    if (exp_fault) begin
      chk(fault && !hvalid, op >= NOPS ? "R5 fault on bad opcode" : "R6 R7 R8 fault on format",
          int'({fault, hvalid}), 2);
      chk(!ready, "R10 ready low in fault", int'(ready), 0);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk(!fault && ready, "R10 release after ack", int'({fault, ready}), 1);
    end else begin
      chk(hvalid && !fault, "R6 R7 R8 legal header strobe", int'({hvalid, fault}), 2);
      chk(!ready, "R9 ready low on strobe", int'(ready), 0);
      chk(opc == 14'(op) && lock == lk, "R2 head fields", int'({lock, opc}), int'({lk, 14'(op)}));
      if (two)
        chk({rep, cond, f1, f2} == {rp, 5'(cd), 5'(a), 5'(b)}, "R3 tail fields",
            int'({rep, cond, f1, f2}), int'({rp, 5'(cd), 5'(a), 5'(b)}));
      else
        chk({rep, cond, f1, f2} == 16'd0, "R4 tail fields zero", int'({rep, cond, f1, f2}), 0);
      @(negedge clk);
      chk(!hvalid && ready, "R9 strobe lasts one cycle", int'({hvalid, ready}), 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3;
    chk(!hvalid && !fault && ready, "R1 reset state", int'({hvalid, fault, ready}), 1);
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk(!hvalid && !fault && ready, "R1 after reset release", int'({hvalid, fault, ready}), 1);

    // R4: single-word headers for every opcode, defined and not
    for (int op = 0; op < NOPS + 2; op++) run_instr(op, op[0], 1'b0, 1'b0, 0, 0, 0);

    // R5: bad opcode with more-flag set; following word must be a new head
    run_instr(16383, 1'b1, 1'b1, 1'b1, 3, 1, 1);
    run_instr(0, 1'b0, 1'b0, 1'b0, 0, 0, 0);

    // R10: fault held, words offered during it are ignored
    @(negedge clk);
    wvalid = 1'b1; wdata = {2'b00, 14'd1};
    @(negedge clk);
    wdata = {2'b00, 14'd0};
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(fault && !ready && opc == 14'd1, "R10 hold and ignore", int'({fault, ready, opc}), 32'h8001);
    end
    wvalid = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(!fault && ready, "R10 release", int'({fault, ready}), 1);

    // sweep: every opcode (plus two undefined) x all format pairs
    for (int op = 0; op < NOPS + 2; op++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          run_instr(op, b[0], 1'b1, a[0], (a + b) % 32, a, b);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule